// File: doc/BRIEF.md
# Pulse-Width Capture Timer

This block is a prescaled 16-bit up-counter with two capture channels. It measures the period and the high time of a digital input. Both channels can watch the same pin, one on rising edges and one on falling edges. In reset mode a chosen input edge also clears the counter and the prescaler. After each trigger edge, one capture register holds the whole cycle length and the other holds the time from the start of the cycle to the opposite edge.

Software sets up the block through a write-only port that takes an address and a data word. The settings are the prescaler, the wrap value, the source and edge of each channel, the trigger source, the slave mode, the interrupt enables, the status clear and a forced-reload command. The counter value, both capture registers, five status flags and one combined interrupt request come out on ports. Both pins pass through a synchroniser. The capture and the counter clear caused by a pin change take effect on the third rising clock edge after the change.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset the counter, both capture registers, all status flags and the interrupt output are zero.
- R2: While run bit 0 of address 0 is set, the counter advances by one every (P+1) clocks, where P is the prescaler value at address 1. While the run bit is clear, the counter holds.
- R3: On an advance from a value at or above the wrap value (address 2), the counter goes to zero instead and sets update flag bit 0.
- R4: Channel A's source is set by bits [1:0] of address 3: 01 selects pin `sigIn`, 10 selects pin `sigAux`, and any other code turns the channel off. Channel B's source is set by bits [4:3] of address 3: 01 selects `sigAux`, 10 selects `sigIn`. A pin with no channel mapped to it leaves both capture registers unchanged. A channel captures on the third rising clock edge after its pin changes.
- R5: Bit 2 of address 3 sets channel A's edge and bit 5 sets channel B's edge. A value of 0 means rising and 1 means falling.
- R6: The trigger source is set by bits [2:0] of address 4. Code 101 selects the `sigIn` pin with channel A's edge bit. Code 110 selects the `sigAux` pin with channel B's edge bit. The trigger source depends only on the pin, never on a channel's mapping. With slave mode bits [6:3] of address 4 equal to 0100, a trigger edge clears the counter and the prescaler. Any other mode gives no clear.
- R7: When one edge both captures and clears, the capture register keeps the value from before the clear. For an input of period T clocks and high time H clocks, with A on rising, B on falling and the trigger on `sigIn` rising, A reads floor((T-1)/(P+1)) and B reads floor((H-1)/(P+1)).
- R8: Writing 1 to bit 0 of address 7 clears the counter and the prescaler in that cycle.
- R9: With bit 1 of address 0 clear, a trigger clear or a forced reload sets update flag bit 0. With bit 1 set, only a wrap sets update flag bit 0.
- R10: Channel A and channel B captures set flag bits 1 and 2. A write to address 6 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A flag being set wins over a clear in the same cycle.
- R11: A capture on A or B while its flag is already set sets overcapture flag bit 3 or bit 4, respectively.
- R12: Output `irq` is high exactly when any of flag bits 0, 1 or 2 is set together with the matching enable bit 0, 1 or 2 of address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| sigIn | input | 1 | Primary measured pin |
| sigAux | input | 1 | Second pin |
| count | output | 16 | Counter value |
| capA | output | 16 | Channel A capture register |
| capB | output | 16 | Channel B capture register |
| flags | output | 5 | Status flags: update, capture A, capture B, overcapture A, overcapture B |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default 16-bit counter and a two-stage synchroniser. With those values, prescalers up to 3 and random periods up to 60 clocks can be measured without a wrap, so the floor formulas of R7 are checked exactly. A small wrap value of 5 brings the overflow boundary within a few cycles. The crossed-mapping case, where the trigger is taken from the unused second pin, is driven to show that no clear happens.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int ADDR_W = 3;
  localparam int FLAG_W = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CHAN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SLAVE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 3'd7;

  localparam logic [1:0] MAP_DIRECT = 2'b01;
  localparam logic [1:0] MAP_CROSS  = 2'b10;
  localparam logic [2:0] TS_PIN1    = 3'b101;
  localparam logic [2:0] TS_PIN2    = 3'b110;
  localparam logic [3:0] SMS_RESET  = 4'b0100;

  localparam int F_UPD  = 0;
  localparam int F_CC1  = 1;
  localparam int F_CC2  = 2;
  localparam int F_OVR1 = 3;
  localparam int F_OVR2 = 4;

  typedef struct packed {
    logic clrCnt;
    logic capA;
    logic capB;
  } dpStrobe_t;
endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[s] <= '0;
        else       stg[s] <= din;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import pct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              sigIn,
  input  logic              sigAux,
  input  logic              ovf,
  output logic              runEn,
  output logic [CNT_W-1:0]  pscVal,
  output logic [CNT_W-1:0]  reloadVal,
  output dpStrobe_t         strobe,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pinSync, pinPrev, pinRise, pinFall;
  logic            urs, polA, polB;
  logic [1:0]      mapA, mapB;
  logic [2:0]      trigSel;
  logic [3:0]      slaveMode;
  logic [2:0]      irqEn;
  logic            ugCmd, trigEdge, trigClr, edgeA, edgeB;
  logic [FLAG_W-1:0] setVec, keepVec;

  pct_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({sigAux, sigIn}),
    .dout(pinSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;

  assign pinRise = pinSync & ~pinPrev;
  assign pinFall = ~pinSync & pinPrev;

  // register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      urs       <= 1'b0;
      pscVal    <= '0;
      reloadVal <= '1;
      mapA      <= 2'b00;
      polA      <= 1'b0;
      mapB      <= 2'b00;
      polB      <= 1'b0;
      trigSel   <= 3'b000;
      slaveMode <= 4'b0000;
      irqEn     <= 3'b000;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CTRL:   {urs, runEn} <= wrData[1:0];
        ADR_PSC:    pscVal <= wrData;
        ADR_RELOAD: reloadVal <= wrData;
        ADR_CHAN:   {polB, mapB, polA, mapA} <= wrData[5:0];
        ADR_SLAVE:  {slaveMode, trigSel} <= wrData[6:0];
        ADR_IRQEN:  irqEn <= wrData[2:0];
        default: ;
      endcase
    end
  end

  assign ugCmd = wrEn && (wrAddr == ADR_CMD) && wrData[0];

  // channel edge selection
  always_comb begin
    case (mapA)
      MAP_DIRECT: edgeA = polA ? pinFall[0] : pinRise[0];
      MAP_CROSS:  edgeA = polA ? pinFall[1] : pinRise[1];
      default:    edgeA = 1'b0;
    endcase
    case (mapB)
      MAP_DIRECT: edgeB = polB ? pinFall[1] : pinRise[1];
      MAP_CROSS:  edgeB = polB ? pinFall[0] : pinRise[0];
      default:    edgeB = 1'b0;
    endcase
    case (trigSel)
      TS_PIN1: trigEdge = polA ? pinFall[0] : pinRise[0];
      TS_PIN2: trigEdge = polB ? pinFall[1] : pinRise[1];
      default: trigEdge = 1'b0;
    endcase
  end

  assign trigClr       = (slaveMode == SMS_RESET) && trigEdge;
  assign strobe.clrCnt = trigClr || ugCmd;
  assign strobe.capA   = edgeA;
  assign strobe.capB   = edgeB;

  // status flags
  always_comb begin
    setVec         = '0;
    setVec[F_UPD]  = ovf || (!urs && strobe.clrCnt);
    setVec[F_CC1]  = edgeA;
    setVec[F_CC2]  = edgeB;
    setVec[F_OVR1] = edgeA && flags[F_CC1];
    setVec[F_OVR2] = edgeB && flags[F_CC2];
    keepVec = (wrEn && wrAddr == ADR_STATUS) ? wrData[FLAG_W-1:0] : '1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flags <= '0;
    else       flags <= (flags & keepVec) | setVec;

  assign irq = |(flags[F_CC2:F_UPD] & irqEn);

  AST_OVF_SETS_UPD: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> flags[F_UPD]); // R3
  AST_URS_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (urs && !ovf && !flags[F_UPD]) |=> !flags[F_UPD]); // R9
  AST_OVERCAPTURE_A: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && flags[F_CC1]) |=> flags[F_OVR1]); // R11
  AST_CAPTURE_SETS_B: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capB |=> flags[F_CC2]); // R10
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CNT_W-1:0] pscVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] capAVal,
  output logic [CNT_W-1:0] capBVal,
  output logic             ovf
);
  logic [CNT_W-1:0] pscCnt;
  logic             advance;

  assign advance = runEn && (pscCnt >= pscVal);
  assign ovf     = advance && (cnt >= reloadVal) && !strobe.clrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pscCnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt    <= '0;
      pscCnt <= '0;
    end else if (runEn) begin
      if (advance) begin
        pscCnt <= '0;
        cnt    <= (cnt >= reloadVal) ? '0 : cnt + 1'b1;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAVal <= '0;
      capBVal <= '0;
    end else begin
      if (strobe.capA) capAVal <= cnt;
      if (strobe.capB) capBVal <= cnt;
    end
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (cnt == '0)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !strobe.clrCnt) |=> $stable(cnt)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> (cnt == '0)); // R3
  AST_CAPTURE_PRECLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capA |=> (capAVal == $past(cnt))); // R7
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              sigIn,
  input  logic              sigAux,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capA,
  output logic [CNT_W-1:0]  capB,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  dpStrobe_t        strobe;
  logic             runEn, ovf;
  logic [CNT_W-1:0] pscVal, reloadVal;

  pct_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .sigIn    (sigIn),
    .sigAux   (sigAux),
    .ovf      (ovf),
    .runEn    (runEn),
    .pscVal   (pscVal),
    .reloadVal(reloadVal),
    .strobe   (strobe),
    .flags    (flags),
    .irq      (irq)
  );

  pct_datapath #(.CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .pscVal   (pscVal),
    .reloadVal(reloadVal),
    .strobe   (strobe),
    .cnt      (count),
    .capAVal  (capA),
    .capBVal  (capB),
    .ovf      (ovf)
  );
endmodule

// File: tb/pwm_capture_timer_test.sv
`timescale 1ns/1ps
module pwm_capture_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        sigIn = 1'b0;
  logic        sigAux = 1'b0;
  logic [15:0] count, capA, capB;
  logic [4:0]  flags;
  logic        irq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwm_capture_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sigIn(sigIn), .sigAux(sigAux), .count(count), .capA(capA), .capB(capB),
    .flags(flags), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int measure(int len, int psc);
    return (len - 1) / (psc + 1);
  endfunction

  task automatic pwmTrain(int hi, int per, int reps);
    for (int i = 0; i < reps; i++) begin
      sigIn = 1'b1; tick(hi);
      sigIn = 1'b0; tick(per - hi);
    end
    sigIn = 1'b1; tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int seedVal, a, b;
    seedVal = $urandom(32'd20240611);
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 capA", capA, 0);
    check("R1 capB", capB, 0);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);

    // R2 / R8 prescaled counting, forced reload, hold when stopped
    wr(3'd1, 16'd2);
    wr(3'd0, 16'd1);
    wr(3'd7, 16'd1);
    check("R8 forced reload clears", count, 0);
    tick(9);
    check("R2 prescale by 3", count, 3);
    wr(3'd0, 16'd0);
    tick(10);
    check("R2 hold while stopped", count, 3);

    // R3 wrap at reload value
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'd3);
    wr(3'd7, 16'd1);
    wr(3'd6, 16'd0);
    tick(4);
    check("R3 before wrap count", count, 5);
    check("R3 before wrap flag", flags[0], 0);
    tick(1);
    check("R3 wrap count", count, 0);
    check("R3 wrap flag", flags[0], 1);
    wr(3'd2, 16'hFFFF);

    // R8 / R9 forced reload and update flag
    wr(3'd0, 16'd1);
    wr(3'd6, 16'd0);
    wr(3'd7, 16'd1);
    check("R8 reload sets update flag", flags[0], 1);
    wr(3'd0, 16'd3);
    wr(3'd6, 16'd0);
    wr(3'd7, 16'd1);
    check("R9 reload blocked by urs", flags[0], 0);
    wr(3'd0, 16'd1);

    // R7 random PWM measurement, A rising, B falling, trigger pin1
    wr(3'd3, 16'h0031);
    wr(3'd4, 16'h0025);
    for (int t = 0; t < 8; t++) begin
      int k, per, hi;
      k   = $urandom_range(3, 0);
      per = $urandom_range(60, 6);
      hi  = $urandom_range(per - 1, 1);
      sigIn = 1'b0;
      wr(3'd1, 16'(k));
      tick(3);
      pwmTrain(hi, per, 3);
      check($sformatf("R7 period T=%0d P=%0d", per, k), capA, measure(per, k));
      check($sformatf("R7 high H=%0d P=%0d", hi, k), capB, measure(hi, k));
    end
    // R7 directed extremes: 1-cycle high and 1-cycle low
    wr(3'd1, 16'd0);
    sigIn = 1'b0; tick(3);
    pwmTrain(1, 7, 3);
    check("R7 high of one cycle", capB, 0);
    check("R7 period 7", capA, 6);
    sigIn = 1'b0; tick(3);
    pwmTrain(6, 7, 3);
    check("R7 high six of seven", capB, 5);

    // R5 inverted edges: A falling, B rising, trigger follows A edge
    wr(3'd3, 16'h0015);
    sigIn = 1'b1; tick(4);
    for (int i = 0; i < 3; i++) begin
      sigIn = 1'b0; tick(11);
      sigIn = 1'b1; tick(19);
    end
    sigIn = 1'b0; tick(6);
    check("R5 falling-edge period", capA, 29);
    check("R5 low time on rising", capB, 10);

    // R4 mapping: A crossed to sigAux rising, B direct to sigAux falling
    wr(3'd3, 16'h002A);
    wr(3'd4, 16'h0000);
    sigIn = 1'b0; tick(4);
    sigAux = 1'b1; tick(9);
    sigAux = 1'b0; tick(6);
    check("R4 aux high via both channels", int'(capB) - int'(capA), 9);
    a = capA; b = capB;
    sigIn = 1'b1; tick(5);
    sigIn = 1'b0; tick(6);
    check("R4 unmapped pin ignored A", capA, a);
    check("R4 unmapped pin ignored B", capB, b);

    // R6 trigger from second pin while B crossed: no clear
    wr(3'd3, 16'h0031);
    wr(3'd4, 16'h0026);
    wr(3'd7, 16'd1);
    pwmTrain(8, 20, 3);
    check("R6 pin2 trigger gives no clear", count >= 60, 1);
    wr(3'd4, 16'h0005);
    wr(3'd7, 16'd1);
    sigIn = 1'b0; tick(2);
    pwmTrain(8, 20, 3);
    check("R6 non-reset mode gives no clear", count >= 60, 1);
    wr(3'd4, 16'h0025);
    sigIn = 1'b0; tick(30);
    sigIn = 1'b1; tick(6);
    check("R6 reset mode clears", count < 10, 1);

    // R9 slave clear and update flag
    wr(3'd0, 16'd3);
    sigIn = 1'b0; tick(50);
    wr(3'd6, 16'd0);
    sigIn = 1'b1; tick(6);
    check("R9 slave clear with urs count", count < 10, 1);
    check("R9 slave clear with urs flag", flags[0], 0);
    wr(3'd0, 16'd1);
    sigIn = 1'b0; tick(50);
    wr(3'd6, 16'd0);
    sigIn = 1'b1; tick(6);
    check("R9 slave clear without urs flag", flags[0], 1);

    // R10 write-zero-to-clear
    sigIn = 1'b0; tick(6);
    wr(3'd6, 16'h001D);
    check("R10 cleared bit", flags[1], 0);
    check("R10 kept bit B", flags[2], 1);
    check("R10 kept bit upd", flags[0], 1);

    // R11 overcapture
    wr(3'd6, 16'd0);
    sigIn = 1'b1; tick(6);
    check("R11 first capture flag", flags[1], 1);
    check("R11 no overcapture yet", flags[3], 0);
    sigIn = 1'b0; tick(6);
    sigIn = 1'b1; tick(6);
    check("R11 overcapture A", flags[3], 1);
    check("R11 no overcapture B", flags[4], 0);

    // R12 interrupt combining
    wr(3'd5, 16'h0002);
    wr(3'd6, 16'd0);
    check("R12 irq low after clear", irq, 0);
    sigIn = 1'b0; tick(6);
    check("R12 masked B flag", irq, 0);
    sigIn = 1'b1; tick(6);
    check("R12 enabled A flag", irq, 1);
    wr(3'd6, 16'h001D);
    check("R12 irq drops with flag", irq, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule